// File: doc/BRIEF.md
# USB Device Address Staging Register

This block is one 32-bit control word of a USB controller that means two different things depending on the controller role. In host role the upper twenty bits hold a 4 KB-aligned base pointer for the periodic schedule. In device role the same word carries a 7-bit device address and a single "advance" flag. When the advance flag is set, a newly written address is not used at once. It is parked in a hidden staging register instead. The controller starts answering to the parked address only when the protocol engine reports that an IN transaction on endpoint 0 was acknowledged, which is the end of the status stage of SET_ADDRESS.

The deferral ends without taking effect if OUT or SETUP traffic reaches endpoint 0 first. A device reset also ends it, and in that case the live address returns to 0. Register writes arrive on a valid/ready port. Ready is always high, so a write is taken in every cycle in which valid is high. The role select and the three protocol-engine strobes are plain single-cycle control pins. Readback is combinational from the stored state. The live device address is driven on its own output so that the packet matcher can use it.

Top module: `usb_addr_stage_reg`

## Requirements
- R1: After reset, `rd_data` reads 0 in both roles, `dev_addr` is 0 and the advance flag is clear.
- R2: In host role (`host_mode`=1), an accepted write stores `wr_data[31:12]`. `rd_data` returns those bits with bits 11:0 always reading zero.
- R3: In device role, `rd_data` bits 31:25 hold the live device address, bit 24 holds the advance flag, and bits 23:0 read zero. The staged address is never visible on `rd_data`.
- R4: In device role, a write with `wr_data[24]`=0 while the advance flag is clear loads `wr_data[31:25]` into the live address. The new address is visible on `dev_addr` in the cycle after the write.
- R5: In device role, a write with `wr_data[24]`=1, or any write while the advance flag is already set, stores `wr_data[31:25]` in the staging register and sets the advance flag. The live address does not change. A device-role write never clears the flag.
- R6: `in_ack_ep0` with the advance flag set copies the staged address into the live address and clears the flag. With the flag clear, it changes nothing.
- R7: `out_or_setup_ep0` clears the advance flag and leaves the live address unchanged.
- R8: `dev_reset` clears the advance flag and forces the live address to 0. It takes priority over the other two strobes.
- R9: A device-role write in a cycle in which any of the three strobes is high is discarded, so the hardware clear always wins.
- R10: Host-role writes leave the device address state unchanged, and device-role writes leave the host base pointer unchanged.
- R11: `wr_ready` is always 1. A write is accepted in every cycle with `wr_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (constant 1) |
| wr_data | input | 32 | Write word |
| in_ack_ep0 | input | 1 | Strobe: IN on endpoint 0 acknowledged |
| out_or_setup_ep0 | input | 1 | Strobe: OUT or SETUP seen on endpoint 0 |
| dev_reset | input | 1 | Strobe: USB bus reset detected |
| rd_data | output | 32 | Readback of the register for the current role |
| dev_addr | output | 7 | Live device address |

## Verification
The hardest case to reach is a collision: a register write and a protocol-engine strobe arriving in the same cycle while a deferral is pending. The outcome depends on the priority order, and it differs from both sequential orders. The bench drives both inputs inside a single cycle task, so it can place a write on the same edge as an IN acknowledge, an OUT/SETUP, or a bus reset. It then checks the live address and the flag on the following cycle. Sweeps over all 128 device addresses cover immediate and deferred writes. A two-write sequence covers a flag set by an earlier write.

// File: rtl/usb_addr_stage_pkg.sv
package usb_addr_stage_pkg;

  localparam int REG_W       = 32;
  localparam int BASE_LSB    = 12;
  localparam int BASE_W      = REG_W - BASE_LSB;
  localparam int DEVADDR_W   = 7;
  localparam int ADV_BIT     = REG_W - DEVADDR_W - 1;
  localparam int DEVADDR_LSB = ADV_BIT + 1;

  typedef struct packed {
    logic in_ack;
    logic out_setup;
    logic bus_reset;
  } ep0_evt_t;

endpackage

// File: rtl/host_base_reg.sv
module host_base_reg
  import usb_addr_stage_pkg::*;
#(
  parameter int BW = BASE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_base,
  output logic [BW-1:0] base_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (wr_en) base_q <= wr_base;
  end

  // R2
  host_base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q == $past(wr_base));

  // R10
  host_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q));

endmodule

// File: rtl/dev_addr_ctrl.sv
module dev_addr_ctrl
  import usb_addr_stage_pkg::*;
#(
  parameter int AW = DEVADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_adv,
  input  ep0_evt_t      evt,
  output logic [AW-1:0] active_q,
  output logic          adv_q
);

  logic [AW-1:0] staged_q;
  logic          any_evt;
  logic          wr_take;
  logic          wr_stage;

  assign any_evt  = evt.in_ack | evt.out_setup | evt.bus_reset;
  assign wr_take  = wr_en & ~any_evt;
  assign wr_stage = wr_adv | adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      staged_q <= '0;
      adv_q    <= 1'b0;
    end else if (evt.bus_reset) begin
      active_q <= '0;
      adv_q    <= 1'b0;
    end else if (evt.in_ack && adv_q) begin
      active_q <= staged_q;
      adv_q    <= 1'b0;
    end else if (evt.out_setup) begin
      adv_q <= 1'b0;
    end else if (wr_take) begin
      if (wr_stage) begin
        staged_q <= wr_addr;
        adv_q    <= 1'b1;
      end else begin
        active_q <= wr_addr;
      end
    end
  end

  // R9
  evt_clears_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !adv_q);

  // R8
  reset_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.bus_reset |=> active_q == '0);

  // R7
  cancel_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.out_setup && !evt.bus_reset && !(evt.in_ack && adv_q)) |=> $stable(active_q));

  // R6
  commit_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.in_ack && adv_q && !evt.bus_reset) |=> active_q == $past(staged_q));

  // R4
  immediate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_adv && !adv_q && !any_evt) |=> active_q == $past(wr_addr));

  // R5
  staged_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_adv || adv_q) && !any_evt) |=> (adv_q && $stable(active_q)));

endmodule

// File: rtl/addr_readback_mux.sv
module addr_readback_mux
  import usb_addr_stage_pkg::*;
(
  input  logic                 host_mode,
  input  logic [BASE_W-1:0]    base_q,
  input  logic [DEVADDR_W-1:0] active_q,
  input  logic                 adv_q,
  output logic [REG_W-1:0]     rd_data
);

  always_comb begin
    if (host_mode) rd_data = {base_q, {BASE_LSB{1'b0}}};
    else           rd_data = {active_q, adv_q, {ADV_BIT{1'b0}}};
  end

  // R3
  always_comb begin
    if (!host_mode) low_zero_dev_chk: assert (rd_data[ADV_BIT-1:0] == '0);
    else            low_zero_host_chk: assert (rd_data[BASE_LSB-1:0] == '0);
  end

endmodule

// File: rtl/usb_addr_stage_reg.sv
module usb_addr_stage_reg
  import usb_addr_stage_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mode,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 in_ack_ep0,
  input  logic                 out_or_setup_ep0,
  input  logic                 dev_reset,
  output logic [REG_W-1:0]     rd_data,
  output logic [DEVADDR_W-1:0] dev_addr
);

  logic                 wr_fire;
  logic [BASE_W-1:0]    base_q;
  logic [DEVADDR_W-1:0] active_q;
  logic                 adv_q;
  ep0_evt_t             evt;
  logic [BASE_LSB-1:0]  unused_low_bits;

  assign wr_ready        = 1'b1;
  assign wr_fire         = wr_valid & wr_ready;
  assign unused_low_bits = wr_data[BASE_LSB-1:0];
  assign evt             = '{in_ack: in_ack_ep0, out_setup: out_or_setup_ep0,
                             bus_reset: dev_reset};

  host_base_reg #(.BW(BASE_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire & host_mode),
    .wr_base (wr_data[REG_W-1:BASE_LSB]),
    .base_q  (base_q)
  );

  dev_addr_ctrl #(.AW(DEVADDR_W)) u_dev (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire & ~host_mode),
    .wr_addr  (wr_data[REG_W-1:DEVADDR_LSB]),
    .wr_adv   (wr_data[ADV_BIT]),
    .evt      (evt),
    .active_q (active_q),
    .adv_q    (adv_q)
  );

  addr_readback_mux u_rd (
    .host_mode (host_mode),
    .base_q    (base_q),
    .active_q  (active_q),
    .adv_q     (adv_q),
    .rd_data   (rd_data)
  );

  assign dev_addr = active_q;

  // R11
  always_comb wr_ready_high_chk: assert (wr_ready == 1'b1);

endmodule

// File: tb/tb_usb_addr_stage_reg.sv
module tb_usb_addr_stage_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        in_ack_ep0 = 1'b0;
  logic        out_or_setup_ep0 = 1'b0;
  logic        dev_reset = 1'b0;
  logic [31:0] rd_data;
  logic [6:0]  dev_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_addr_stage_reg dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .in_ack_ep0(in_ack_ep0), .out_or_setup_ep0(out_or_setup_ep0),
    .dev_reset(dev_reset), .rd_data(rd_data), .dev_addr(dev_addr)
  );

  function automatic logic [31:0] dev_word(input logic [6:0] a, input logic adv);
    return {a, adv, 24'h0};
  endfunction

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk_dev(input string tag, input logic [6:0] a, input logic adv);
    chk32({tag, " dev_addr"}, {25'h0, dev_addr}, {25'h0, a});
    chk32({tag, " rd_data"}, rd_data, dev_word(a, adv));
  endtask

  // one clock: inputs applied after negedge, removed after next negedge
  task automatic cyc(input logic v, input logic [31:0] d,
                     input logic ia, input logic os, input logic rs);
    wr_valid = v; wr_data = d;
    in_ack_ep0 = ia; out_or_setup_ep0 = os; dev_reset = rs;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
    in_ack_ep0 = 1'b0; out_or_setup_ep0 = 1'b0; dev_reset = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state in both roles
    host_mode = 1'b0;
    #1 chk_dev("R1", 7'd0, 1'b0);
    host_mode = 1'b1;
    #1 chk32("R1 host rd", rd_data, 32'h0);
    chk32("R11 ready", {31'h0, wr_ready}, 32'h1);

    // R2 host sweep, low bits written as ones must read zero
    base = '0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v;
      v = (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << (i % 32));
      wr(v);
      base = v & 32'hFFFF_F000;
      chk32("R2 host readback", rd_data, base);
    end
    host_mode = 1'b0;
    #1 chk_dev("R10 host writes leave device", 7'd0, 1'b0);

    // R4 / R3 immediate sweep over all addresses, junk in bits 23:0
    for (int a = 0; a < 128; a++) begin
      wr({a[6:0], 1'b0, 24'hA5C3_FF ^ a[23:0]});
      chk_dev("R4 immediate", a[6:0], 1'b0);
    end
    host_mode = 1'b1;
    #1 chk32("R10 device writes leave base", rd_data, base);
    host_mode = 1'b0;

    // R5 / R6 deferred sweep
    for (int a = 0; a < 128; a++) begin
      logic [6:0] old_a;
      old_a = 7'(127 - a);
      wr({old_a, 1'b0, 24'h0});
      wr({a[6:0], 1'b1, 24'h0});
      chk_dev("R5 staged hidden", old_a, 1'b1);
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
      chk_dev("R6 commit on IN ack", a[6:0], 1'b0);
    end

    // R5 flag set by an earlier write; later write with bit24=0 still staged
    wr(dev_word(7'd3, 1'b0));
    wr(dev_word(7'd40, 1'b1));
    wr(dev_word(7'd77, 1'b0));
    chk_dev("R5 earlier flag keeps staging", 7'd3, 1'b1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk_dev("R5 earlier flag commit", 7'd77, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk_dev("R6 IN ack without flag", 7'd77, 1'b0);

    // R7 cancel by SETUP
    wr(dev_word(7'd5, 1'b0));
    wr(dev_word(7'd9, 1'b1));
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
    chk_dev("R7 setup cancels", 7'd5, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk_dev("R7 later IN ack no commit", 7'd5, 1'b0);

    // R8 bus reset during pending deferral
    wr(dev_word(7'd20, 1'b0));
    wr(dev_word(7'd30, 1'b1));
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk_dev("R8 reset clears", 7'd0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk_dev("R8 IN ack after reset", 7'd0, 1'b0);
    wr(dev_word(7'd30, 1'b1));
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b1);
    chk_dev("R8 reset beats IN ack", 7'd0, 1'b0);

    // R9 collisions
    wr(dev_word(7'd11, 1'b0));
    wr(dev_word(7'd22, 1'b1));
    cyc(1'b1, dev_word(7'd33, 1'b1), 1'b1, 1'b0, 1'b0);
    chk_dev("R9 write with IN ack dropped", 7'd22, 1'b0);
    cyc(1'b1, dev_word(7'd44, 1'b0), 1'b0, 1'b1, 1'b0);
    chk_dev("R9 immediate write with OUT dropped", 7'd22, 1'b0);
    wr(dev_word(7'd60, 1'b1));
    cyc(1'b1, dev_word(7'd61, 1'b1), 1'b0, 1'b1, 1'b0);
    chk_dev("R9 write with SETUP, flag cleared", 7'd22, 1'b0);
    cyc(1'b1, dev_word(7'd62, 1'b0), 1'b0, 1'b0, 1'b1);
    chk_dev("R9 write with bus reset dropped", 7'd0, 1'b0);

    // R10 host write while a deferral is pending
    wr(dev_word(7'd15, 1'b0));
    wr(dev_word(7'd16, 1'b1));
    host_mode = 1'b1;
    wr(32'hFFFF_FFFF);
    chk32("R2 host all ones", rd_data, 32'hFFFF_F000);
    host_mode = 1'b0;
    #1 chk_dev("R10 pending survives host write", 7'd15, 1'b1);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
    chk_dev("R6 commit after host write", 7'd16, 1'b0);

    // R1 asynchronous reset returns to zero
    rst_n = 1'b0;
    #1 chk_dev("R1 reset again", 7'd0, 1'b0);
    host_mode = 1'b1;
    #1 chk32("R1 host after reset", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule